// File: doc/BRIEF.md
# Two-Level Interrupt Priority Resolver

The block picks one interrupt to present to a processor out of a wide vector of request lines. Each source carries two configuration bits, held in the block and written through a small register port: an enable and a level (high or low). A request competes only when it is pending, enabled, and its level's global enable is set. The level set by software is ranked first, so a high-level source beats every low-level source whatever its index. Within a level the lowest index wins. Some indices are reserved. They have no storage, cannot be written, and never win.

The winner's index, its level and a valid flag are registered, so they follow the request inputs one clock later. A two-deep nesting model tracks the handlers in service. An acknowledge strobe takes the presented winner into service. A return strobe retires the most recent handler. While a low-level handler runs, only high-level requests are presented. While a high-level handler runs, nothing is presented.

A mode input selects vectored operation. When it is low the levels no longer rank the sources. All enabled requests then compete by index alone, and the winner is handled as a high-level one.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, `win_valid` is 0 and no handler is in service. Every source reads back enable 0. Every non-reserved source reads back level 1 (high), and reserved sources read level 0.
- R2: A source competes only when its `irq_pend` bit is 1, its enable bit is 1, and the global enable for its configured level (`glb_en_hi` or `glb_en_lo`) is 1. Otherwise it never appears on `win_vec`.
- R3: With `vec_mode`=1, any competing high-level source wins over every competing low-level source, whatever their indices. `win_hi` is 1 for a high-level winner and 0 for a low-level one.
- R4: Among competing sources of the same level, the one with the lowest index wins.
- R5: `win_valid`, `win_vec` and `win_hi` are registered. They reflect the inputs sampled at the previous rising clock edge. `win_valid` is 0 when nothing competes.
- R6: Reserved indices are 4, 6, 17–19, 36, 37, 43, 60, 76, 78, 79, 112, 116–119 and 124–143. Writes to them are ignored, they read back 0 for both bits, and they never win. Writes to indices at 144 or above are also ignored.
- R7: While a low-level handler is in service and no high-level one is, only high-level sources are presented. A pending low-level source leaves `win_valid` at 0.
- R8: `irq_ack` with `win_valid`=1 puts the presented winner's level into service. `irq_ack` with `win_valid`=0 does nothing. While a high-level handler is in service, `win_valid` stays 0. `irq_ret` retires the high-level handler first, then the low-level one. When `irq_ret` and `irq_ack` arrive in the same cycle, the acknowledge is ignored.
- R9: With `vec_mode`=0, the level bits do not rank sources and the lowest competing index wins. R2 gating still applies. `win_hi` reads 1, and an acknowledged winner blocks all presentation until `irq_ret`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_mode | input | 1 | 1: two-level ranking; 0: index-only ranking |
| glb_en_hi | input | 1 | Global enable for high-level sources |
| glb_en_lo | input | 1 | Global enable for low-level sources |
| irq_pend | input | N_SRC (144) | Pending request per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | IDX_W (8) | Source index to write |
| cfg_wen | input | 1 | Enable value to write |
| cfg_whi | input | 1 | Level value to write (1 = high) |
| cfg_raddr | input | IDX_W (8) | Source index to read back |
| cfg_ren | output | 1 | Enable bit of `cfg_raddr` |
| cfg_rhi | output | 1 | Level bit of `cfg_raddr` |
| irq_ack | input | 1 | Presented winner taken into service |
| irq_ret | input | 1 | Return from the most recent handler |
| win_valid | output | 1 | A winner is presented |
| win_vec | output | IDX_W (8) | Index of the winner |
| win_hi | output | 1 | Level of the winner |
| svc_lo | output | 1 | Low-level handler in service |
| svc_hi | output | 1 | High-level handler in service |

## Verification
Directed patterns check each ranking rule on its own. A high-level source with a large index is paired with a low-level source with a small index, which tells level-first ranking from index-first ranking. Several sources of the same level show whether the lowest index or some other index is chosen. Reserved, disabled and globally gated sources are driven alone, so a leak of any of them shows as a false valid. The nesting sequence acknowledges a low-level winner and then a high-level one, offers low-level requests while each is in service, and returns twice; this separates the blocking rules and the unstack order. Batches of random sparse patterns under random configurations, with both modes and all global enable settings, are compared against a model in the bench.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Default source count and the index width derived from it.
  localparam int unsigned N_SRC_DEF = 144;

  // Indices with no source attached.
  function automatic logic slot_reserved(input int unsigned i);
    return (i == 4) || (i == 6) ||
           (i >= 17 && i <= 19) ||
           (i == 36) || (i == 37) || (i == 43) || (i == 60) ||
           (i == 76) || (i == 78) || (i == 79) || (i == 112) ||
           (i >= 116 && i <= 119) ||
           (i >= 124 && i <= 143);
  endfunction

  // Rank slot encoding used by the resolver.
  typedef enum logic {RANK_FIRST = 1'b0, RANK_SECOND = 1'b1} rank_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned N  = 144,
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wen,
  input  logic          whi,
  input  logic [IW-1:0] raddr,
  output logic          ren,
  output logic          rhi,
  output logic [N-1:0]  en_vec,
  output logic [N-1:0]  hi_vec
);
  import irq_prio_pkg::*;

  function automatic logic [N-1:0] build_rsvd();
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < int'(N); i++) m[i] = slot_reserved(i);
    return m;
  endfunction

  localparam logic [N-1:0] RSVD = build_rsvd();

  logic [N-1:0] en_q, hi_q;
  logic [N-1:0] wr_hit;

  always_comb begin
    wr_hit = '0;
    for (int i = 0; i < int'(N); i++)
      wr_hit[i] = we && (int'(waddr) == i) && !RSVD[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      hi_q <= ~RSVD;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        if (wr_hit[i]) begin
          en_q[i] <= wen;
          hi_q[i] <= whi;
        end
      end
    end
  end

  assign en_vec = en_q & ~RSVD;
  assign hi_vec = hi_q & ~RSVD;

  always_comb begin
    ren = 1'b0;
    rhi = 1'b0;
    if (int'(raddr) < int'(N)) begin
      ren = en_vec[raddr];
      rhi = hi_vec[raddr];
    end
  end

  // R6: reserved slots hold no state once written.
  p_rsvd_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(raddr) < int'(N) && slot_reserved(int'(raddr))) |-> (!ren && !rhi));

  // R6: a write to a reserved slot leaves both bits at zero afterwards.
  p_rsvd_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(waddr) < int'(N) && slot_reserved(int'(waddr))) |=>
      (en_vec[$past(waddr)] == 1'b0));

endmodule

// File: rtl/irq_find_first.sv
module irq_find_first #(
  parameter int unsigned N  = 144,
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);

  // Scan from the top so the last assignment is the lowest set index.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R4: the chosen index is requesting and nothing below it is.
  p_lowest_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

  // R2: no hit without a request.
  p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !hit);

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ret,
  input  logic win_valid,
  input  logic win_hi,
  output logic svc_lo,
  output logic svc_hi
);

  logic take_hi, take_lo;

  assign take_hi = ack && !ret && win_valid && win_hi;
  assign take_lo = ack && !ret && win_valid && !win_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_lo <= 1'b0;
      svc_hi <= 1'b0;
    end else if (ret) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end else begin
      if (take_hi) svc_hi <= 1'b1;
      if (take_lo) svc_lo <= 1'b1;
    end
  end

  // R8: returning from a nested high handler resumes the low one.
  p_ret_unstack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_hi && svc_lo && ret) |=> (svc_lo && !svc_hi));

  // R7: a low handler never starts on top of a high one.
  p_no_lo_over_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi |=> !$rose(svc_lo));

  // R8: an acknowledge with nothing presented changes nothing.
  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ret && !win_valid) |=> ($stable(svc_lo) && $stable(svc_hi)));

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int unsigned N_SRC = irq_prio_pkg::N_SRC_DEF,
  parameter int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_mode,
  input  logic             glb_en_hi,
  input  logic             glb_en_lo,
  input  logic [N_SRC-1:0] irq_pend,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_waddr,
  input  logic             cfg_wen,
  input  logic             cfg_whi,
  input  logic [IDX_W-1:0] cfg_raddr,
  output logic             cfg_ren,
  output logic             cfg_rhi,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_vec,
  output logic             win_hi,
  output logic             svc_lo,
  output logic             svc_hi
);
  import irq_prio_pkg::*;

  localparam int unsigned N_RANK = 2;

  logic [N_SRC-1:0] en_vec, hi_vec;
  logic [N_SRC-1:0] hi_cand, lo_cand;
  logic [N_SRC-1:0] rank_req [N_RANK];
  logic             rank_hit [N_RANK];
  logic [IDX_W-1:0] rank_idx [N_RANK];
  logic             rank_ok  [N_RANK];
  logic             nx_valid, nx_hi;
  logic [IDX_W-1:0] nx_vec;

  irq_cfg_regs #(.N(N_SRC), .IW(IDX_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .waddr  (cfg_waddr),
    .wen    (cfg_wen),
    .whi    (cfg_whi),
    .raddr  (cfg_raddr),
    .ren    (cfg_ren),
    .rhi    (cfg_rhi),
    .en_vec (en_vec),
    .hi_vec (hi_vec)
  );

  // Per-level candidate sets after enable and global gating.
  assign hi_cand = irq_pend & en_vec &  hi_vec & {N_SRC{glb_en_hi}};
  assign lo_cand = irq_pend & en_vec & ~hi_vec & {N_SRC{glb_en_lo}};

  // First rank: high level (or everything in index-only mode).
  assign rank_req[RANK_FIRST]  = vec_mode ? hi_cand : (hi_cand | lo_cand);
  assign rank_req[RANK_SECOND] = vec_mode ? lo_cand : '0;
  assign rank_ok[RANK_FIRST]   = !svc_hi;
  assign rank_ok[RANK_SECOND]  = vec_mode && !svc_hi && !svc_lo;

  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    irq_find_first #(.N(N_SRC), .IW(IDX_W)) u_ff (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (rank_req[r]),
      .hit   (rank_hit[r]),
      .idx   (rank_idx[r])
    );
  end

  always_comb begin
    nx_valid = 1'b0;
    nx_vec   = '0;
    nx_hi    = 1'b0;
    if (rank_hit[RANK_FIRST] && rank_ok[RANK_FIRST]) begin
      nx_valid = 1'b1;
      nx_vec   = rank_idx[RANK_FIRST];
      nx_hi    = 1'b1;
    end else if (rank_hit[RANK_SECOND] && rank_ok[RANK_SECOND]) begin
      nx_valid = 1'b1;
      nx_vec   = rank_idx[RANK_SECOND];
      nx_hi    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_vec   <= '0;
      win_hi    <= 1'b0;
    end else begin
      win_valid <= nx_valid;
      win_vec   <= nx_vec;
      win_hi    <= nx_hi;
    end
  end

  irq_nest_ctl u_nest (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (irq_ack),
    .ret       (irq_ret),
    .win_valid (win_valid),
    .win_hi    (win_hi),
    .svc_lo    (svc_lo),
    .svc_hi    (svc_hi)
  );

  // R6: a reserved index is never presented.
  p_rsvd_never_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> !slot_reserved(int'(win_vec)));

  // R3: a low winner means no high candidate was there a cycle earlier.
  p_hi_before_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_hi) |-> $past(!rank_hit[RANK_FIRST]));

  // R8: a high handler in service blocks presentation.
  p_hi_svc_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_hi) |-> !win_valid);

  // R7: under a low handler only high winners appear.
  p_lo_svc_hi_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(svc_lo) && win_valid) |-> win_hi);

  // R9: index-only mode always reports the high level.
  p_flat_reports_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!vec_mode) && win_valid) |-> win_hi);

endmodule

// File: tb/irq_prio_resolver_test.sv
`timescale 1ns/1ps
module irq_prio_resolver_test;
  localparam int N  = 144;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vec_mode = 1'b1, glb_en_hi = 1'b1, glb_en_lo = 1'b1;
  logic [N-1:0]  irq_pend = '0;
  logic          cfg_we = 1'b0, cfg_wen = 1'b0, cfg_whi = 1'b0;
  logic [IW-1:0] cfg_waddr = '0, cfg_raddr = '0;
  logic          cfg_ren, cfg_rhi;
  logic          irq_ack = 1'b0, irq_ret = 1'b0;
  logic          win_valid, win_hi, svc_lo, svc_hi;
  logic [IW-1:0] win_vec;

  int n_chk = 0, n_fail = 0;
  logic m_en [N];
  logic m_hi [N];

  always #2.5 clk = ~clk;

  irq_prio_resolver uut (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .glb_en_hi(glb_en_hi),
    .glb_en_lo(glb_en_lo), .irq_pend(irq_pend), .cfg_we(cfg_we),
    .cfg_waddr(cfg_waddr), .cfg_wen(cfg_wen), .cfg_whi(cfg_whi),
    .cfg_raddr(cfg_raddr), .cfg_ren(cfg_ren), .cfg_rhi(cfg_rhi),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .win_valid(win_valid),
    .win_vec(win_vec), .win_hi(win_hi), .svc_lo(svc_lo), .svc_hi(svc_hi)
  );

  // Reserved list restated from the requirement text.
  function automatic bit tb_rsvd(int i);
    int lst[] = '{4, 6, 17, 18, 19, 36, 37, 43, 60, 76, 78, 79, 112,
                  116, 117, 118, 119};
    if (i >= 124) return 1'b1;
    foreach (lst[k]) if (lst[k] == i) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(string tag, bit ev, int evec, bit ehi);
    chk({tag, " valid"}, int'(win_valid), int'(ev));
    if (ev) begin
      chk({tag, " vec"}, int'(win_vec), evec);
      chk({tag, " level"}, int'(win_hi), int'(ehi));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_pend = '0; irq_ack = 0; irq_ret = 0; cfg_we = 0;
    vec_mode = 1; glb_en_hi = 1; glb_en_lo = 1;
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_hi[i] = !tb_rsvd(i); end
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(int idx, bit en, bit hi);
    cfg_we = 1; cfg_waddr = IW'(idx); cfg_wen = en; cfg_whi = hi;
    step();
    cfg_we = 0;
    if (idx < N && !tb_rsvd(idx)) begin m_en[idx] = en; m_hi[idx] = hi; end
  endtask

  // Expected winner with nothing in service.
  task automatic model(output bit ev, output int evec, output bit ehi);
    ev = 0; evec = 0; ehi = 0;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      for (int i = 0; i < N; i++) begin
        bit gate = m_hi[i] ? glb_en_hi : glb_en_lo;
        bit lvl_ok = vec_mode ? (int'(m_hi[i]) == lvl) : (lvl == 1);
        if (!ev && irq_pend[i] && m_en[i] && gate && lvl_ok) begin
          ev = 1; evec = i; ehi = vec_mode ? m_hi[i] : 1'b1;
        end
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_win("R1 reset", 0, 0, 0);
    chk("R1 svc_lo", int'(svc_lo), 0);
    chk("R1 svc_hi", int'(svc_hi), 0);
    cfg_raddr = 8'd0;   #1; chk("R1 en idx0", int'(cfg_ren), 0);
    chk("R1 hi idx0", int'(cfg_rhi), 1);
    cfg_raddr = 8'd123; #1; chk("R1 hi idx123", int'(cfg_rhi), 1);
    cfg_raddr = 8'd4;   #1; chk("R1 hi rsvd4", int'(cfg_rhi), 0);
  endtask

  task automatic t_gating();
    do_reset();
    wr(5, 1, 0); wr(10, 1, 0);
    irq_pend[7] = 1; step();
    chk_win("R2 not enabled", 0, 0, 0);
    irq_pend[10] = 1; irq_pend[5] = 1; step();
    chk_win("R4 low pair", 1, 5, 0);
    glb_en_lo = 0; step();
    chk_win("R2 global low off", 0, 0, 0);
    glb_en_lo = 1; wr(5, 0, 0); step();
    chk_win("R2 disabled after write", 1, 10, 0);
  endtask

  task automatic t_levels();
    do_reset();
    wr(3, 1, 0); wr(123, 1, 1); wr(80, 1, 1); wr(32, 1, 1); wr(122, 1, 1);
    irq_pend[3] = 1; irq_pend[123] = 1; step();
    chk_win("R3 high large index wins", 1, 123, 1);
    irq_pend[80] = 1; irq_pend[32] = 1; irq_pend[122] = 1; step();
    chk_win("R4 lowest high", 1, 32, 1);
    glb_en_hi = 0; step();
    chk_win("R2 high gated, low shows", 1, 3, 0);
  endtask

  task automatic t_reserved();
    do_reset();
    wr(4, 1, 1); wr(130, 1, 1); wr(150, 1, 1);
    cfg_raddr = 8'd4; #1;
    chk("R6 rsvd en read", int'(cfg_ren), 0);
    chk("R6 rsvd hi read", int'(cfg_rhi), 0);
    cfg_raddr = 8'd130; #1;
    chk("R6 rsvd130 en read", int'(cfg_ren), 0);
    irq_pend = '0; irq_pend[4] = 1; irq_pend[130] = 1; step();
    chk_win("R6 rsvd never wins", 0, 0, 0);
  endtask

  task automatic t_latency();
    do_reset();
    wr(9, 1, 1);
    irq_pend[9] = 1; #1;
    chk_win("R5 before edge", 0, 0, 0);
    step();
    chk_win("R5 after edge", 1, 9, 1);
    irq_pend[9] = 0; #1;
    chk_win("R5 holds until edge", 1, 9, 1);
    step();
    chk_win("R5 drops", 0, 0, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    wr(10, 1, 0); wr(20, 1, 0); wr(48, 1, 1);
    irq_pend[20] = 1; step();
    chk_win("R4 single low", 1, 20, 0);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R8 ack low svc_lo", int'(svc_lo), 1);
    step();
    chk_win("R7 own low masked", 0, 0, 0);
    irq_pend[10] = 1; step();
    chk_win("R7 lower low masked", 0, 0, 0);
    irq_pend[48] = 1; step();
    chk_win("R7 high preempts", 1, 48, 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R8 nested svc_hi", int'(svc_hi), 1);
    chk("R8 nested svc_lo", int'(svc_lo), 1);
    step();
    chk_win("R8 high blocks", 0, 0, 0);
    irq_ret = 1; irq_ack = 1; step(); irq_ret = 0; irq_ack = 0;
    chk("R8 ret clears high", int'(svc_hi), 0);
    chk("R8 ret keeps low", int'(svc_lo), 1);
    step();
    chk_win("R7 high shows again", 1, 48, 1);
    irq_pend[48] = 0; step();
    chk_win("R7 low still masked", 0, 0, 0);
    irq_ret = 1; step(); irq_ret = 0;
    chk("R8 second ret", int'(svc_lo), 0);
    step();
    chk_win("R8 idle low presented", 1, 10, 0);
    irq_pend = '0; step(); step();
    irq_ack = 1; step(); irq_ack = 0;
    chk("R8 idle ack ignored lo", int'(svc_lo), 0);
    chk("R8 idle ack ignored hi", int'(svc_hi), 0);
  endtask

  task automatic t_flat();
    do_reset();
    wr(3, 1, 0); wr(123, 1, 1);
    vec_mode = 0; irq_pend[3] = 1; irq_pend[123] = 1; step();
    chk_win("R9 index only", 1, 3, 1);
    irq_ack = 1; step(); irq_ack = 0; step();
    chk_win("R9 ack blocks all", 0, 0, 0);
    irq_ret = 1; step(); irq_ret = 0; step();
    chk_win("R9 resumes", 1, 3, 1);
  endtask

  task automatic t_sweep();
    do_reset();
    for (int round = 0; round < 4; round++) begin
      for (int i = 0; i < N; i++) wr(i, $urandom_range(0, 1), $urandom_range(0, 1));
      for (int p = 0; p < 40; p++) begin
        bit ev, ehi; int evec;
        logic [N-1:0] a, b;
        a = {$urandom, $urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom, $urandom};
        irq_pend = a & b & {$urandom, $urandom, $urandom, $urandom, $urandom};
        vec_mode  = $urandom_range(0, 3) != 0;
        glb_en_hi = $urandom_range(0, 3) != 0;
        glb_en_lo = $urandom_range(0, 3) != 0;
        model(ev, evec, ehi);
        step();
        chk_win("R3 R4 R9 sweep", ev, evec, ehi);
      end
    end
  endtask

  initial begin
    step();
    t_reset();
    t_gating();
    t_levels();
    t_reserved();
    t_latency();
    t_nesting();
    t_flat();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule